// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block carries a small processor core from the moment an exception is recognised to the moment the first instruction of its handler may be fetched. It watches reset sources (a power-on pin, a manual-reset pin and a watchdog overflow strobe) together with the non-reset exception causes: an interrupt request with its priority level, an address-error flag, a trap request and the decoder's opcode flags. It then runs the memory traffic that the entry needs over a single-outstanding request/acknowledge master port.

A reset entry reads a pair of words from a fixed base: the new program counter first, then the new stack pointer. It also clears the vector base register and raises the interrupt mask to its highest level. A non-reset entry pushes the status register and then the program counter below the current stack pointer. It then reads the handler address from the vector table at the vector base plus four times the vector number. The core's registers are not held here. The core presents their current values, and the block returns one-cycle write strobes with the new values in the cycle it raises `handler_go`.

Opcode faults are sorted by delay-slot context. An undefined opcode outside a slot is a general fault. An undefined opcode inside a slot is a slot fault, and so is a program-counter-changing instruction inside a slot.

Top module: `exc_entry_seq`

## Requirements
- R1: A low-to-high transition on `por_pin` starts a reset entry that reads address 0x00000000 and then 0x00000004. The first word becomes `pc_wdata` and the second becomes `sp_wdata`.
- R2: A low-to-high transition on `mres_pin` starts a reset entry that reads address 0x00000008 and then 0x0000000C, with the same use of the two words as R1.
- R3: A one-cycle `wdt_ovf` pulse starts a reset entry. With `wdt_manual` = 0 it uses the pair at 0x0 and 0x4; with `wdt_manual` = 1 it uses the pair at 0x8 and 0xC. When a power-on cause and a manual cause arrive in the same cycle, the power-on pair is used.
- R4: A reset entry finishes, in the cycle after the acknowledge of its second read, with one cycle in which `handler_go`, `pc_we`, `sp_we`, `vbr_clr` and `imask_we` are all high and `imask_wdata` = 0xF.
- R5: A non-reset entry first writes `core_sr` to `core_sp`−4 and then writes `core_pc` to `core_sp`−8. It completes with `sp_we` high and `sp_wdata` = `core_sp`−8.
- R6: After the two pushes, a non-reset entry reads `core_vbr` + 4 × vector number. The word read becomes `pc_wdata` with `pc_we` high, in the cycle after that read's acknowledge.
- R7: An interrupt is taken only in a cycle where `irq_req` and `insn_done` are both high, using `irq_vec`. Its completion raises `imask_we` with `imask_wdata` = `irq_level`.
- R8: Address-error, trap and opcode-fault entries complete with `imask_we` low and `vbr_clr` low.
- R9: `illegal_op` with `in_slot` low takes vector `GEN_ILL_VEC` (default 4). `in_slot` high together with `illegal_op` or `pc_mod` takes vector `SLOT_ILL_VEC` (default 6). `pc_mod` with `in_slot` low starts nothing.
- R10: When several non-reset causes are present in one cycle, one is taken in this order: address error (`ae_vec`), slot fault, general fault, trap (`trap_vec`), interrupt.
- R11: `busy` is low when idle and high from the cycle after acceptance until `handler_go`. Non-reset causes presented while busy are dropped: they start no entry and do not alter the running one.
- R12: A reset cause arriving while an entry is running abandons it. The reset entry of R1–R3 follows, and only one `handler_go` is produced.
- R13: `mem_req` is low when idle. While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values (a reset cause excepted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_pin | input | 1 | Power-on reset pin, acts on its rising edge |
| mres_pin | input | 1 | Manual reset pin, acts on its rising edge |
| wdt_ovf | input | 1 | Watchdog overflow strobe, one cycle |
| wdt_manual | input | 1 | Watchdog reset kind: 0 power-on, 1 manual |
| insn_done | input | 1 | Current instruction completes this cycle |
| irq_req | input | 1 | Arbitrated interrupt request |
| irq_level | input | 4 | Priority level of the interrupt |
| irq_vec | input | 8 | Vector number of the interrupt |
| addr_err | input | 1 | Address error detected |
| ae_vec | input | 8 | Vector number of the address error |
| trap_req | input | 1 | Trap instruction executing |
| trap_vec | input | 8 | Vector number of the trap |
| illegal_op | input | 1 | Undefined opcode decoded |
| pc_mod | input | 1 | Decoded instruction changes the program counter |
| in_slot | input | 1 | Decoded instruction sits in a delay slot |
| core_pc | input | 32 | Program counter value to save |
| core_sp | input | 32 | Current stack pointer |
| core_sr | input | 32 | Current status register |
| core_vbr | input | 32 | Current vector base |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, completes the request |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| busy | output | 1 | Entry sequence in progress |
| handler_go | output | 1 | One-cycle pulse: core may start at the new PC |
| pc_we | output | 1 | Program counter write strobe |
| pc_wdata | output | 32 | New program counter |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_wdata | output | 32 | New stack pointer |
| vbr_clr | output | 1 | Clear vector base strobe |
| imask_we | output | 1 | Interrupt mask write strobe |
| imask_wdata | output | 4 | New interrupt mask |

## Verification
The assertions assume a watchdog overflow lasts exactly one cycle. They also assume the memory raises `mem_ack` only against a pending request and for a single cycle. The stimulus keeps to this: each cause is driven for one cycle, and the bench memory acknowledges after a chosen number of wait cycles and drops the acknowledge at once. The bench does not change `core_*` while an entry runs, because the block takes their values at acceptance.

// File: rtl/exc_entry_pkg.sv
// Package: widths and types shared by the exception entry sequencer.
// Assumes a 32-bit datapath, 8-bit vector numbers and a 4-bit mask.
package exc_entry_pkg;

    localparam int unsigned XLEN   = 32;
    localparam int unsigned VEC_W  = 8;
    localparam int unsigned MASK_W = 4;

    typedef enum logic [2:0] {
        EK_IRQ      = 3'd0,
        EK_ADDR     = 3'd1,
        EK_ILL_GEN  = 3'd2,
        EK_ILL_SLOT = 3'd3,
        EK_TRAP     = 3'd4
    } exc_kind_e;

    typedef struct packed {
        logic              valid;
        exc_kind_e         kind;
        logic [VEC_W-1:0]  vec;
        logic [MASK_W-1:0] lvl;
    } exc_req_t;

endpackage

// File: rtl/exc_reset_detect.sv
// Reset cause detector.
// Turns rising edges of the two reset pins and a one-cycle watchdog
// strobe into a single reset event plus its kind (power-on or manual).
// Assumes pins are already synchronous to clk; wdt_ovf lasts one cycle.
module exc_reset_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic por_pin,
    input  logic mres_pin,
    input  logic wdt_ovf,
    input  logic wdt_manual,
    output logic rst_evt,
    output logic rst_manual
);

    logic por_q;
    logic mres_q;
    logic por_rise;
    logic mres_rise;
    logic wdt_por;
    logic wdt_mres;

    // Remember last pin levels; reset to high so no edge appears at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_q  <= 1'b1;
            mres_q <= 1'b1;
        end else begin
            por_q  <= por_pin;
            mres_q <= mres_pin;
        end
    end

    // Combine causes; a power-on cause outranks a manual one.
    always_comb begin
        por_rise   = por_pin & ~por_q;
        mres_rise  = mres_pin & ~mres_q;
        wdt_por    = wdt_ovf & ~wdt_manual;
        wdt_mres   = wdt_ovf & wdt_manual;
        rst_evt    = por_rise | mres_rise | wdt_ovf;
        rst_manual = ~(por_rise | wdt_por) & (mres_rise | wdt_mres);
    end

    AST_EVT_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_evt && !wdt_ovf) |-> ($rose(por_pin) || $rose(mres_pin)));  // R3

endmodule

// File: rtl/exc_classify.sv
// Non-reset cause classifier.
// Sorts opcode faults by delay-slot context, gates interrupts on
// instruction completion and picks one cause by fixed ranking.
// Assumes all inputs are valid for the cycle they are high.
module exc_classify
    import exc_entry_pkg::*;
#(
    parameter logic [VEC_W-1:0] GEN_ILL_VEC  = 8'd4,
    parameter logic [VEC_W-1:0] SLOT_ILL_VEC = 8'd6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done,
    input  logic              irq_req,
    input  logic [MASK_W-1:0] irq_level,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic              addr_err,
    input  logic [VEC_W-1:0]  ae_vec,
    input  logic              trap_req,
    input  logic [VEC_W-1:0]  trap_vec,
    input  logic              illegal_op,
    input  logic              pc_mod,
    input  logic              in_slot,
    output exc_req_t          req
);

    logic ill_gen;
    logic ill_slot;
    logic irq_ok;

    // Delay-slot context decides which opcode fault is raised.
    always_comb begin
        ill_gen  = illegal_op & ~in_slot;
        ill_slot = in_slot & (illegal_op | pc_mod);
        irq_ok   = irq_req & insn_done;
    end

    // Fixed ranking: address error, slot fault, general fault, trap, irq.
    always_comb begin
        req       = '0;
        req.kind  = EK_IRQ;
        req.valid = addr_err | ill_slot | ill_gen | trap_req | irq_ok;
        if (addr_err) begin
            req.kind = EK_ADDR;
            req.vec  = ae_vec;
        end else if (ill_slot) begin
            req.kind = EK_ILL_SLOT;
            req.vec  = SLOT_ILL_VEC;
        end else if (ill_gen) begin
            req.kind = EK_ILL_GEN;
            req.vec  = GEN_ILL_VEC;
        end else if (trap_req) begin
            req.kind = EK_TRAP;
            req.vec  = trap_vec;
        end else if (irq_ok) begin
            req.kind = EK_IRQ;
            req.vec  = irq_vec;
            req.lvl  = irq_level;
        end
    end

    AST_ONE_FAULT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ill_gen, ill_slot}));  // R9

endmodule

// File: rtl/exc_seq_fsm.sv
// Entry sequencer state machine and memory master.
// Reset flow: two vector reads, then register strobes.
// Other flow: two stack pushes, one vector read, then register strobes.
// Assumes one outstanding memory request; mem_ack only while mem_req.
// A reset event restarts the machine from any state.
module exc_seq_fsm
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] POR_BASE  = 32'h0000_0000,
    parameter logic [XLEN-1:0] MRES_BASE = 32'h0000_0008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_evt,
    input  logic              rst_manual,
    input  exc_req_t          req,
    input  logic [XLEN-1:0]   core_pc,
    input  logic [XLEN-1:0]   core_sp,
    input  logic [XLEN-1:0]   core_sr,
    input  logic [XLEN-1:0]   core_vbr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic              mem_ack,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              busy,
    output logic              handler_go,
    output logic              pc_we,
    output logic [XLEN-1:0]   pc_wdata,
    output logic              sp_we,
    output logic [XLEN-1:0]   sp_wdata,
    output logic              vbr_clr,
    output logic              imask_we,
    output logic [MASK_W-1:0] imask_wdata
);

    localparam int unsigned    PAD_W = XLEN - VEC_W - 2;
    localparam logic [XLEN-1:0] WORD = XLEN'(4);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RV_PC,
        ST_RV_SP,
        ST_PUSH_SR,
        ST_PUSH_PC,
        ST_FETCH_VEC
    } st_e;

    st_e               state;
    logic              manual_q;
    logic              kind_irq_q;
    logic [MASK_W-1:0] lvl_q;
    logic [VEC_W-1:0]  vec_q;
    logic [XLEN-1:0]   sp_q;
    logic [XLEN-1:0]   sr_q;
    logic [XLEN-1:0]   pc_q;
    logic [XLEN-1:0]   vbr_q;
    logic [XLEN-1:0]   pc_tmp;
    logic [XLEN-1:0]   rst_base;

    // Pick the vector pair base for the reset kind in progress.
    always_comb rst_base = manual_q ? MRES_BASE : POR_BASE;

    // Step through the sequence and emit the completion strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            manual_q    <= 1'b0;
            kind_irq_q  <= 1'b0;
            lvl_q       <= '0;
            vec_q       <= '0;
            sp_q        <= '0;
            sr_q        <= '0;
            pc_q        <= '0;
            vbr_q       <= '0;
            pc_tmp      <= '0;
            handler_go  <= 1'b0;
            pc_we       <= 1'b0;
            pc_wdata    <= '0;
            sp_we       <= 1'b0;
            sp_wdata    <= '0;
            vbr_clr     <= 1'b0;
            imask_we    <= 1'b0;
            imask_wdata <= '0;
        end else begin
            handler_go <= 1'b0;
            pc_we      <= 1'b0;
            sp_we      <= 1'b0;
            vbr_clr    <= 1'b0;
            imask_we   <= 1'b0;
            if (rst_evt) begin
                state    <= ST_RV_PC;
                manual_q <= rst_manual;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (req.valid && !handler_go) begin
                            kind_irq_q <= (req.kind == EK_IRQ);
                            lvl_q      <= req.lvl;
                            vec_q      <= req.vec;
                            sp_q       <= core_sp;
                            sr_q       <= core_sr;
                            pc_q       <= core_pc;
                            vbr_q      <= core_vbr;
                            state      <= ST_PUSH_SR;
                        end
                    end
                    ST_RV_PC: begin
                        if (mem_ack) begin
                            pc_tmp <= mem_rdata;
                            state  <= ST_RV_SP;
                        end
                    end
                    ST_RV_SP: begin
                        if (mem_ack) begin
                            pc_we       <= 1'b1;
                            pc_wdata    <= pc_tmp;
                            sp_we       <= 1'b1;
                            sp_wdata    <= mem_rdata;
                            vbr_clr     <= 1'b1;
                            imask_we    <= 1'b1;
                            imask_wdata <= '1;
                            handler_go  <= 1'b1;
                            state       <= ST_IDLE;
                        end
                    end
                    ST_PUSH_SR: begin
                        if (mem_ack) state <= ST_PUSH_PC;
                    end
                    ST_PUSH_PC: begin
                        if (mem_ack) state <= ST_FETCH_VEC;
                    end
                    ST_FETCH_VEC: begin
                        if (mem_ack) begin
                            pc_we       <= 1'b1;
                            pc_wdata    <= mem_rdata;
                            sp_we       <= 1'b1;
                            sp_wdata    <= sp_q - (WORD + WORD);
                            imask_we    <= kind_irq_q;
                            imask_wdata <= lvl_q;
                            handler_go  <= 1'b1;
                            state       <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Drive the memory master from the current state and captured values.
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_RV_PC:     mem_addr = rst_base;
            ST_RV_SP:     mem_addr = rst_base + WORD;
            ST_PUSH_SR: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q - WORD;
                mem_wdata = sr_q;
            end
            ST_PUSH_PC: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q - (WORD + WORD);
                mem_wdata = pc_q;
            end
            ST_FETCH_VEC: mem_addr = vbr_q + {{PAD_W{1'b0}}, vec_q, 2'b00};
            default:      mem_req = 1'b0;
        endcase
    end

    // Busy covers every state but idle.
    always_comb busy = (state != ST_IDLE);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !rst_evt) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));  // R13

    AST_GO_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        handler_go |-> $past(mem_req && mem_ack));  // R4

    AST_MASK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        imask_we |-> (vbr_clr || kind_irq_q));  // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);  // R11

endmodule

// File: rtl/exc_entry_seq.sv
// Top level of the exception entry sequencer.
// Wires the reset cause detector, the non-reset classifier and the
// sequencing state machine. Assumes the core holds core_* steady and
// stays stalled while busy is high.
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter logic [VEC_W-1:0] GEN_ILL_VEC  = 8'd4,
    parameter logic [VEC_W-1:0] SLOT_ILL_VEC = 8'd6,
    parameter logic [XLEN-1:0]  POR_BASE     = 32'h0000_0000,
    parameter logic [XLEN-1:0]  MRES_BASE    = 32'h0000_0008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_pin,
    input  logic              mres_pin,
    input  logic              wdt_ovf,
    input  logic              wdt_manual,
    input  logic              insn_done,
    input  logic              irq_req,
    input  logic [MASK_W-1:0] irq_level,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic              addr_err,
    input  logic [VEC_W-1:0]  ae_vec,
    input  logic              trap_req,
    input  logic [VEC_W-1:0]  trap_vec,
    input  logic              illegal_op,
    input  logic              pc_mod,
    input  logic              in_slot,
    input  logic [XLEN-1:0]   core_pc,
    input  logic [XLEN-1:0]   core_sp,
    input  logic [XLEN-1:0]   core_sr,
    input  logic [XLEN-1:0]   core_vbr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic              mem_ack,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              busy,
    output logic              handler_go,
    output logic              pc_we,
    output logic [XLEN-1:0]   pc_wdata,
    output logic              sp_we,
    output logic [XLEN-1:0]   sp_wdata,
    output logic              vbr_clr,
    output logic              imask_we,
    output logic [MASK_W-1:0] imask_wdata
);

    logic     rst_evt;
    logic     rst_manual;
    exc_req_t req;

    exc_reset_detect i_rst_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_pin    (por_pin),
        .mres_pin   (mres_pin),
        .wdt_ovf    (wdt_ovf),
        .wdt_manual (wdt_manual),
        .rst_evt    (rst_evt),
        .rst_manual (rst_manual)
    );

    exc_classify #(
        .GEN_ILL_VEC  (GEN_ILL_VEC),
        .SLOT_ILL_VEC (SLOT_ILL_VEC)
    ) i_classify (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_done  (insn_done),
        .irq_req    (irq_req),
        .irq_level  (irq_level),
        .irq_vec    (irq_vec),
        .addr_err   (addr_err),
        .ae_vec     (ae_vec),
        .trap_req   (trap_req),
        .trap_vec   (trap_vec),
        .illegal_op (illegal_op),
        .pc_mod     (pc_mod),
        .in_slot    (in_slot),
        .req        (req)
    );

    exc_seq_fsm #(
        .POR_BASE  (POR_BASE),
        .MRES_BASE (MRES_BASE)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_evt     (rst_evt),
        .rst_manual  (rst_manual),
        .req         (req),
        .core_pc     (core_pc),
        .core_sp     (core_sp),
        .core_sr     (core_sr),
        .core_vbr    (core_vbr),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .handler_go  (handler_go),
        .pc_we       (pc_we),
        .pc_wdata    (pc_wdata),
        .sp_we       (sp_we),
        .sp_wdata    (sp_wdata),
        .vbr_clr     (vbr_clr),
        .imask_we    (imask_we),
        .imask_wdata (imask_wdata)
    );

endmodule

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        por_pin, mres_pin, wdt_ovf, wdt_manual;
    logic        insn_done, irq_req, addr_err, trap_req;
    logic        illegal_op, pc_mod, in_slot;
    logic [3:0]  irq_level;
    logic [7:0]  irq_vec, ae_vec, trap_vec;
    logic [31:0] core_pc, core_sp, core_sr, core_vbr;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, handler_go, pc_we, sp_we, vbr_clr, imask_we;
    logic [31:0] pc_wdata, sp_wdata;
    logic [3:0]  imask_wdata;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 0;

    // bench memory state
    int lat = 0;
    int wcnt = 0;
    logic [31:0] log_addr [16];
    logic        log_we   [16];
    logic [31:0] log_data [16];
    int n_log = 0;
    int n_go = 0;
    int n_unstable = 0;
    logic        g_pc_we, g_sp_we, g_vbr_clr, g_imask_we;
    logic [31:0] g_pc, g_sp;
    logic [3:0]  g_imask;
    logic        pend = 0;
    logic [31:0] p_addr;
    logic        p_we;

    always #4 clk = ~clk;

    exc_entry_seq i_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .por_pin(por_pin), .mres_pin(mres_pin),
        .wdt_ovf(wdt_ovf), .wdt_manual(wdt_manual), .insn_done(insn_done),
        .irq_req(irq_req), .irq_level(irq_level), .irq_vec(irq_vec),
        .addr_err(addr_err), .ae_vec(ae_vec), .trap_req(trap_req),
        .trap_vec(trap_vec), .illegal_op(illegal_op), .pc_mod(pc_mod),
        .in_slot(in_slot), .core_pc(core_pc), .core_sp(core_sp),
        .core_sr(core_sr), .core_vbr(core_vbr), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy),
        .handler_go(handler_go), .pc_we(pc_we), .pc_wdata(pc_wdata),
        .sp_we(sp_we), .sp_wdata(sp_wdata), .vbr_clr(vbr_clr),
        .imask_we(imask_we), .imask_wdata(imask_wdata)
    );

    function automatic logic [31:0] mw(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    assign mem_rdata = mw(mem_addr);

    // memory acknowledge after lat wait cycles, one cycle wide
    always @(posedge clk) begin
        if (!mem_req || mem_ack) begin
            wcnt    <= 0;
            mem_ack <= 1'b0;
        end else if (wcnt >= lat) begin
            mem_ack <= 1'b1;
        end else begin
            wcnt <= wcnt + 1;
        end
    end

    // monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (mem_req && mem_ack && n_log < 16) begin
            log_addr[n_log] = mem_addr;
            log_we[n_log]   = mem_we;
            log_data[n_log] = mem_wdata;
            n_log++;
        end
        if (pend && mem_req && (mem_addr !== p_addr || mem_we !== p_we))
            n_unstable++;
        pend   = mem_req && !mem_ack;
        p_addr = mem_addr;
        p_we   = mem_we;
        if (handler_go) begin
            n_go++;
            g_pc_we = pc_we; g_pc = pc_wdata;
            g_sp_we = sp_we; g_sp = sp_wdata;
            g_vbr_clr = vbr_clr;
            g_imask_we = imask_we; g_imask = imask_wdata;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wait_go(input int target, input string req);
        for (int i = 0; i < 200 && n_go < target; i++) @(negedge clk);
        chk(req, n_go, target);
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // a reset entry ends with mask 0xF and all strobes together
    task automatic chk_reset_done(input string req, input logic [31:0] base);
        chk(req, log_addr[n_log-2], base);
        chk(req, log_addr[n_log-1], base + 4);
        chk(req, {g_pc_we, g_sp_we, g_vbr_clr, g_imask_we}, 4'hF);
        chk(req, g_pc, mw(base));
        chk(req, g_sp, mw(base + 4));
        chk({req, " R4"}, g_imask, 4'hF);
    endtask

    // non-reset entry: two pushes then a vector read
    task automatic chk_entry(input string req, input logic [7:0] vec,
                             input logic mask_wr, input logic [3:0] lvl);
        logic [31:0] va;
        va = core_vbr + {22'd0, vec, 2'b00};
        chk({req, " R5"}, n_log, 3);
        chk({req, " R5"}, {log_we[0], log_we[1], log_we[2]}, 3'b110);
        chk({req, " R5"}, log_addr[0], core_sp - 4);
        chk({req, " R5"}, log_data[0], core_sr);
        chk({req, " R5"}, log_addr[1], core_sp - 8);
        chk({req, " R5"}, log_data[1], core_pc);
        chk({req, " R6"}, log_addr[2], va);
        chk({req, " R6"}, {g_pc_we, g_sp_we, g_vbr_clr}, 3'b110);
        chk({req, " R6"}, g_pc, mw(va));
        chk({req, " R5"}, g_sp, core_sp - 8);
        chk(req, g_imask_we, mask_wr);
        if (mask_wr) chk({req, " R7"}, g_imask, lvl);
    endtask

    task automatic start_t();
        n_log = 0;
    endtask

    task automatic t_reset_state();
        chk("R11 busy after reset", busy, 0);
        chk("R13 mem_req after reset", mem_req, 0);
        chk("R4 no go after reset", n_go, 0);
    endtask

    task automatic t_por();
        int g = n_go;
        start_t();
        @(negedge clk) por_pin = 0;
        @(negedge clk) por_pin = 1;
        wait_go(g + 1, "R1");
        chk("R1 reads", n_log, 2);
        chk_reset_done("R1", 32'h0);
    endtask

    task automatic t_mres();
        int g = n_go;
        start_t();
        @(negedge clk) mres_pin = 0;
        @(negedge clk) mres_pin = 1;
        wait_go(g + 1, "R2");
        chk("R2 reads", n_log, 2);
        chk_reset_done("R2", 32'h8);
    endtask

    task automatic t_wdt();
        int g = n_go;
        start_t();
        @(negedge clk) begin wdt_ovf = 1; wdt_manual = 0; end
        @(negedge clk) wdt_ovf = 0;
        wait_go(g + 1, "R3 wdt power-on");
        chk_reset_done("R3 wdt power-on", 32'h0);
        start_t();
        @(negedge clk) begin wdt_ovf = 1; wdt_manual = 1; end
        @(negedge clk) wdt_ovf = 0;
        wait_go(g + 2, "R3 wdt manual");
        chk_reset_done("R3 wdt manual", 32'h8);
        start_t();
        @(negedge clk) begin por_pin = 0; mres_pin = 0; end
        @(negedge clk) begin por_pin = 1; mres_pin = 1; end
        wait_go(g + 3, "R3 both pins");
        chk_reset_done("R3 both pins", 32'h0);
    endtask

    task automatic t_trap();
        int g = n_go;
        start_t();
        @(negedge clk) begin trap_req = 1; trap_vec = 8'h21; end
        @(negedge clk) trap_req = 0;
        chk("R11 busy during entry", busy, 1);
        wait_go(g + 1, "R6 trap");
        chk_entry("R8 trap", 8'h21, 0, 4'h0);
        @(negedge clk);
        chk("R11 busy after go", busy, 0);
    endtask

    task automatic t_irq();
        int g = n_go;
        start_t();
        @(negedge clk) begin irq_req = 1; insn_done = 0; irq_level = 4'h9; irq_vec = 8'h40; end
        @(negedge clk) irq_req = 0;
        idle_cycles(6);
        chk("R7 irq without insn_done", {busy, 31'(n_log)}, 0);
        @(negedge clk) begin irq_req = 1; insn_done = 1; end
        @(negedge clk) begin irq_req = 0; insn_done = 0; end
        wait_go(g + 1, "R7 irq");
        chk_entry("R7 irq", 8'h40, 1, 4'h9);
    endtask

    task automatic t_priority();
        int g = n_go;
        start_t();
        @(negedge clk) begin
            addr_err = 1; ae_vec = 8'h09; illegal_op = 1; in_slot = 0;
            trap_req = 1; trap_vec = 8'h22; irq_req = 1; insn_done = 1;
            irq_level = 4'h3; irq_vec = 8'h41;
        end
        @(negedge clk) begin addr_err = 0; illegal_op = 0; trap_req = 0; irq_req = 0; insn_done = 0; end
        wait_go(g + 1, "R10 all causes");
        chk_entry("R10 addr error first", 8'h09, 0, 4'h0);
        start_t();
        @(negedge clk) begin illegal_op = 1; trap_req = 1; irq_req = 1; insn_done = 1; end
        @(negedge clk) begin illegal_op = 0; trap_req = 0; irq_req = 0; insn_done = 0; end
        wait_go(g + 2, "R10 fault over trap");
        chk_entry("R10 fault over trap", 8'd4, 0, 4'h0);
        start_t();
        @(negedge clk) begin trap_req = 1; irq_req = 1; insn_done = 1; end
        @(negedge clk) begin trap_req = 0; irq_req = 0; insn_done = 0; end
        wait_go(g + 3, "R10 trap over irq");
        chk_entry("R10 trap over irq", 8'h22, 0, 4'h0);
    endtask

    task automatic t_illegal();
        int g = n_go;
        start_t();
        @(negedge clk) begin pc_mod = 1; in_slot = 0; end
        @(negedge clk) pc_mod = 0;
        idle_cycles(6);
        chk("R9 pc_mod outside slot", {busy, 31'(n_log)}, 0);
        @(negedge clk) begin illegal_op = 1; in_slot = 1; end
        @(negedge clk) begin illegal_op = 0; in_slot = 0; end
        wait_go(g + 1, "R9 slot undefined");
        chk_entry("R9 slot undefined", 8'd6, 0, 4'h0);
        start_t();
        @(negedge clk) begin pc_mod = 1; in_slot = 1; end
        @(negedge clk) begin pc_mod = 0; in_slot = 0; end
        wait_go(g + 2, "R9 slot branch");
        chk_entry("R9 slot branch", 8'd6, 0, 4'h0);
        start_t();
        @(negedge clk) illegal_op = 1;
        @(negedge clk) illegal_op = 0;
        wait_go(g + 3, "R9 general");
        chk_entry("R9 general", 8'd4, 0, 4'h0);
    endtask

    task automatic t_busy();
        int g = n_go;
        start_t();
        @(negedge clk) begin trap_req = 1; trap_vec = 8'h30; end
        @(negedge clk) begin trap_req = 0; addr_err = 1; ae_vec = 8'h0A; irq_req = 1; insn_done = 1; end
        @(negedge clk) begin addr_err = 0; irq_req = 0; insn_done = 0; end
        wait_go(g + 1, "R11 busy entry");
        chk_entry("R11 ignored while busy", 8'h30, 0, 4'h0);
        idle_cycles(8);
        chk("R11 no second entry", n_go, g + 1);
        chk("R11 no extra traffic", n_log, 3);
    endtask

    task automatic t_abort();
        int g = n_go;
        start_t();
        @(negedge clk) begin addr_err = 1; ae_vec = 8'h0B; end
        @(negedge clk) addr_err = 0;
        for (int i = 0; i < 50 && n_log < 1; i++) @(negedge clk);
        mres_pin = 0;
        @(negedge clk) mres_pin = 1;
        wait_go(g + 1, "R12 abort");
        idle_cycles(6);
        chk("R12 single go", n_go, g + 1);
        chk_reset_done("R12 abort", 32'h8);
    endtask

    task automatic t_handshake();
        int g = n_go;
        start_t();
        lat = 3;
        n_unstable = 0;
        @(negedge clk) begin trap_req = 1; trap_vec = 8'h11; end
        @(negedge clk) trap_req = 0;
        wait_go(g + 1, "R13 slow memory");
        chk("R13 held request", n_unstable, 0);
        chk_entry("R13 slow memory", 8'h11, 0, 4'h0);
        lat = 0;
    endtask

    initial begin
        rst_n = 0; por_pin = 1; mres_pin = 1; wdt_ovf = 0; wdt_manual = 0;
        insn_done = 0; irq_req = 0; irq_level = 0; irq_vec = 0;
        addr_err = 0; ae_vec = 0; trap_req = 0; trap_vec = 0;
        illegal_op = 0; pc_mod = 0; in_slot = 0;
        core_pc = 32'h0000_1236; core_sp = 32'h0000_8000;
        core_sr = 32'h0000_00F1; core_vbr = 32'h0040_0000;
        idle_cycles(4);
        rst_n = 1;
        idle_cycles(2);
        t_reset_state();
        t_por();
        t_mres();
        t_wdt();
        t_trap();
        t_irq();
        t_priority();
        t_illegal();
        t_busy();
        t_abort();
        t_handshake();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule